// File: doc/BRIEF.md
# Multiplexed-Bus Transfer Sequencer

This block runs one processor bus transfer at a time on a bus whose lower 16 lines carry the address first and the data afterwards, and which has a few extra upper address lines. A client presents a request with these fields: memory or I/O space, read or write, a full address, a flag for the upper data byte, and the write data. The block then steps through the clock states of the transfer. It drives an address-latch pulse for the external address latch, and a space select that is held for the whole transfer. It drives the direction and enable pins of the data transceivers and separate active-low read and write strobes. The device end stretches the transfer by holding the ready input low. When the transfer ends, the block returns the captured read data with a single-cycle completion pulse.

The request side is a valid/ready handshake. The client raises `req_valid` and keeps every request field stable until it sees `req_ready` high at a rising clock edge. That edge is the hand-over. `req_ready` is high only while no transfer is in progress, so at most one transfer is ever outstanding. The response side cannot be held back: `rsp_valid` is high for exactly one cycle, and the client must take `rsp_rdata` in that cycle.

Top module: `mmbus_xfer_ctrl`

## Requirements
- R1: After reset the block is idle. In the idle state `req_ready` is 1, `rd_n`, `wr_n`, `den_n` and `bhe_n` are 1, and `ale`, `ad_oe` and `rsp_valid` are 0. `req_ready` is 1 only while idle.
- R2: The cycle after a request is accepted is T1. In T1 `ale` is 1, `ad_oe` is 1, `ad_out` carries address bits 15:0 and `ahi_out` carries the upper address bits. `ale` is 0 in every other cycle.
- R3: From T2 through T4, `ahi_out` carries status. Bit 0 is the memory flag, bit 1 is the write flag, and any further bits are 0.
- R4: From T1 through T4, `m_io` is 1 for a memory transfer and 0 for an I/O transfer.
- R5: From T1 through T4, `dt_r` is 1 for a write and 0 for a read.
- R6: In T2, T3 and every wait state, `den_n` is 0. In the same cycles `rd_n` is 0 for a read and `wr_n` is 0 for a write. All three are 1 in T1 and T4, and `rd_n` and `wr_n` are never 0 together.
- R7: From T1 through T4, `bhe_n` is 0 exactly when the request flagged the upper byte.
- R8: `bus_ready` is sampled at the clock edge that ends T3 and at the edge that ends each wait state. Every low sample adds one wait state, so a transfer with N low samples lasts 4+N cycles.
- R9: During a read, `ad_oe` is 0 from T2 through T4. During a write, `ad_oe` is 1 and `ad_out` equals the write data from T2 through T4.
- R10: `rsp_valid` is 1 only in T4, which lasts one cycle, and this holds for reads and writes. For a read, `rsp_rdata` equals `ad_in` as sampled at the edge that entered T4.
- R11: A request raised while a transfer is in progress is not accepted. Its T1 follows only after the current T4 and one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken at this edge |
| req_is_mem | input | 1 | 1 memory space, 0 I/O space |
| req_is_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Transfer address |
| req_hi_byte | input | 1 | Upper data byte takes part |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse (T4) |
| rsp_rdata | output | DATA_W | Read data captured entering T4 |
| bus_ready | input | 1 | Device ready; low adds wait states |
| ale | output | 1 | Address latch pulse |
| m_io | output | 1 | Space select, 1 memory |
| dt_r | output | 1 | Transceiver direction, 1 transmit |
| den_n | output | 1 | Transceiver enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | Upper byte enable, active low |
| ad_out | output | DATA_W | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for shared lines |
| ad_in | input | DATA_W | Shared address/data lines, sampled value |
| ahi_out | output | ADDR_W-DATA_W | Upper address, then status |

## Verification
The bench builds the block with its default widths: a 20-bit address over 16 shared lines, which leaves four upper lines. With these widths the bench can tell apart the upper address in T1 from the status nibble in the later states, and it can check both status bits and the zero bits above them. The bench models the device side and holds ready low for a chosen number of samples, from none to five. This puts transfers of minimum length and stretched transfers of both directions and both spaces within reach. It also makes back-to-back requests, so that the rule that only an idle block accepts a request is exercised.

// File: rtl/mmbus_pkg.sv
package mmbus_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  localparam int unsigned STAT_MEM_BIT = 0;
  localparam int unsigned STAT_WR_BIT  = 1;
endpackage

// File: rtl/mmbus_req_hold.sv
module mmbus_req_hold #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_mem,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_hi,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              q_mem,
  output logic              q_write,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_hi,
  output logic [DATA_W-1:0] q_wdata
);
  // Request fields are frozen at acceptance and stay put for the whole transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_mem   <= 1'b0;
      q_write <= 1'b0;
      q_addr  <= '0;
      q_hi    <= 1'b0;
      q_wdata <= '0;
    end else if (take) begin
      q_mem   <= in_mem;
      q_write <= in_write;
      q_addr  <= in_addr;
      q_hi    <= in_hi;
      q_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/mmbus_tstate_seq.sv
module mmbus_tstate_seq
  import mmbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    bus_ready,
  output tstate_e st,
  output logic    idle,
  output logic    capture
);
  tstate_e st_nxt;

  assign idle    = (st == TS_IDLE);
  // Edge leaving T3 or a wait state with the device ready enters T4
  assign capture = ((st == TS_T3) || (st == TS_TW)) && bus_ready;

  always_comb begin
    st_nxt = st;
    unique case (st)
      TS_IDLE: if (start) st_nxt = TS_T1;
      TS_T1:   st_nxt = TS_T2;
      TS_T2:   st_nxt = TS_T3;
      TS_T3:   st_nxt = bus_ready ? TS_T4 : TS_TW;
      TS_TW:   st_nxt = bus_ready ? TS_T4 : TS_TW;
      TS_T4:   st_nxt = TS_IDLE;
      default: st_nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= TS_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/mmbus_pin_drive.sv
module mmbus_pin_drive
  import mmbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  tstate_e                  st,
  input  logic                     q_mem,
  input  logic                     q_write,
  input  logic [ADDR_W-1:0]        q_addr,
  input  logic                     q_hi,
  input  logic [DATA_W-1:0]        q_wdata,
  output logic                     ale,
  output logic                     m_io,
  output logic                     dt_r,
  output logic                     den_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     bhe_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] ahi_out
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic              busy;
  logic              addr_ph;
  logic              strobe_ph;
  logic              data_ph;
  logic [HI_W-1:0]   status;

  assign busy      = (st != TS_IDLE);
  assign addr_ph   = (st == TS_T1);
  assign strobe_ph = (st == TS_T2) || (st == TS_T3) || (st == TS_TW);
  assign data_ph   = strobe_ph || (st == TS_T4);

  // Status nibble on the upper lines: kind of transfer, remaining bits zero
  for (genvar i = 0; i < HI_W; i++) begin : g_stat
    if (i == STAT_MEM_BIT) begin : g_mem
      assign status[i] = q_mem;
    end else if (i == STAT_WR_BIT) begin : g_wr
      assign status[i] = q_write;
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end

  always_comb begin
    ale   = addr_ph;
    m_io  = busy && q_mem;
    dt_r  = busy && q_write;
    bhe_n = !(busy && q_hi);
    den_n = !strobe_ph;
    rd_n  = !(strobe_ph && !q_write);
    wr_n  = !(strobe_ph && q_write);
    ad_oe = addr_ph || (data_ph && q_write);

    if (addr_ph)                 ad_out = q_addr[DATA_W-1:0];
    else if (data_ph && q_write) ad_out = q_wdata;
    else                         ad_out = '0;

    if (addr_ph)      ahi_out = q_addr[ADDR_W-1:DATA_W];
    else if (data_ph) ahi_out = status;
    else              ahi_out = '0;
  end
endmodule

// File: rtl/mmbus_rd_capture.sv
module mmbus_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              is_write,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture && !is_write) rsp_rdata <= ad_in;
    end
  end
endmodule

// File: rtl/mmbus_xfer_ctrl.sv
module mmbus_xfer_ctrl
  import mmbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_is_mem,
  input  logic                     req_is_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_hi_byte,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic                     bus_ready,
  output logic                     ale,
  output logic                     m_io,
  output logic                     dt_r,
  output logic                     den_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     bhe_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] ahi_out
);
  tstate_e           st;
  logic              idle;
  logic              capture;
  logic              take;
  logic              q_mem;
  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic              q_hi;
  logic [DATA_W-1:0] q_wdata;

  assign req_ready = idle;
  assign take      = req_valid && idle;

  mmbus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_mem(req_is_mem), .in_write(req_is_write), .in_addr(req_addr),
    .in_hi(req_hi_byte), .in_wdata(req_wdata),
    .q_mem(q_mem), .q_write(q_write), .q_addr(q_addr),
    .q_hi(q_hi), .q_wdata(q_wdata)
  );

  mmbus_tstate_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(take), .bus_ready(bus_ready),
    .st(st), .idle(idle), .capture(capture)
  );

  mmbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .st(st), .q_mem(q_mem), .q_write(q_write), .q_addr(q_addr),
    .q_hi(q_hi), .q_wdata(q_wdata),
    .ale(ale), .m_io(m_io), .dt_r(dt_r), .den_n(den_n),
    .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ahi_out(ahi_out)
  );

  mmbus_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .is_write(q_write),
    .ad_in(ad_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/mmbus_xfer_ctrl_chk.sv
module mmbus_xfer_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic bus_ready,
  input logic ale,
  input logic m_io,
  input logic den_n,
  input logic rd_n,
  input logic wr_n,
  input logic bhe_n,
  input logic ad_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && den_n && bhe_n && !ale && !rsp_valid)); // R1
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready); // R1
  AST_ALE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale); // R2
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_SPACE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(m_io)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R6
  AST_STROBE_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !den_n); // R6
  AST_END_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(bus_ready)); // R8
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !ale); // R11
endmodule

bind mmbus_xfer_ctrl mmbus_xfer_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .bus_ready(bus_ready), .ale(ale), .m_io(m_io),
  .den_n(den_n), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .ad_oe(ad_oe)
);

// File: tb/mmbus_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module mmbus_xfer_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int HW = AW - DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_is_mem = 1'b0, req_is_write = 1'b0, req_hi_byte = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          bus_ready = 1'b1;
  logic          ale, m_io, dt_r, den_n, rd_n, wr_n, bhe_n, ad_oe;
  logic [DW-1:0] ad_out;
  logic [DW-1:0] ad_in = '0;
  logic [HW-1:0] ahi_out;

  mmbus_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_mmbus_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_mem(req_is_mem), .req_is_write(req_is_write), .req_addr(req_addr),
    .req_hi_byte(req_hi_byte), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_ready(bus_ready),
    .ale(ale), .m_io(m_io), .dt_r(dt_r), .den_n(den_n), .rd_n(rd_n), .wr_n(wr_n),
    .bhe_n(bhe_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ahi_out(ahi_out)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          mem;
    logic          wr;
    logic          hi;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    int            waits;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver: push the expected transfer, then hold the request until accepted
  task automatic send(logic mem, logic wr, logic [AW-1:0] a, logic hi,
                      logic [DW-1:0] wd, logic [DW-1:0] rd, int waits);
    item_t it;
    it.addr = a; it.mem = mem; it.wr = wr; it.hi = hi;
    it.wdata = wd; it.rdata = rd; it.waits = waits;
    exp_q.push_back(it);
    req_valid = 1'b1; req_is_mem = mem; req_is_write = wr;
    req_addr = a; req_hi_byte = hi; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor and device model: pops one expected item per ALE pulse
  bit    busy = 0;
  int    k = 0;
  item_t cur;
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (!busy) begin
        if (ale) begin
          if (exp_q.size() == 0) begin
            check("R2 unexpected ALE", 32'd1, 32'd0);
          end else begin
            cur = exp_q.pop_front();
            busy = 1; k = 0;
            check("R2 ad_oe in T1", 32'(ad_oe), 32'd1);
            check("R2 low address", 32'(ad_out), 32'(cur.addr[DW-1:0]));
            check("R2 upper address", 32'(ahi_out), 32'(cur.addr[AW-1:DW]));
            check("R4 m_io T1", 32'(m_io), 32'(cur.mem));
            check("R5 dt_r T1", 32'(dt_r), 32'(cur.wr));
            check("R7 bhe_n T1", 32'(bhe_n), 32'(!cur.hi));
            check("R6 strobes idle in T1", 32'({rd_n, wr_n, den_n}), 32'h7);
          end
        end else begin
          check("R1 idle outputs", 32'({rd_n, wr_n, den_n, bhe_n, ad_oe, rsp_valid}), 32'h3C);
        end
      end else begin
        k++;
        check("R11/R2 ALE during transfer", 32'(ale), 32'd0);
        check("R1 ready low while busy", 32'(req_ready), 32'd0);
        check("R3 status", 32'(ahi_out), 32'({cur.wr, cur.mem}));
        check("R4 m_io held", 32'(m_io), 32'(cur.mem));
        check("R5 dt_r held", 32'(dt_r), 32'(cur.wr));
        check("R7 bhe_n held", 32'(bhe_n), 32'(!cur.hi));
        check("R9 ad_oe", 32'(ad_oe), 32'(cur.wr));
        if (cur.wr) check("R9 write data", 32'(ad_out), 32'(cur.wdata));
        if (k < 3 + cur.waits) begin
          check("R6 den_n active", 32'(den_n), 32'd0);
          check("R6 rd_n", 32'(rd_n), 32'(cur.wr));
          check("R6 wr_n", 32'(wr_n), 32'(!cur.wr));
          check("R8/R10 no early done", 32'(rsp_valid), 32'd0);
        end else begin
          check("R6 strobes off in T4", 32'({rd_n, wr_n, den_n}), 32'h7);
          check("R8/R10 done in T4", 32'(rsp_valid), 32'd1);
          if (!cur.wr) check("R10 read data", 32'(rsp_rdata), 32'(cur.rdata));
          n_done++;
          busy = 0;
        end
      end
      bus_ready = busy ? (k >= 2 + cur.waits) : 1'b1;
      ad_in = busy ? cur.rdata : 16'h0;
    end
  end

  initial begin
    #(200000 * 5);
    check("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", 32'(req_ready), 32'd1);
    check("R1 reset strobes", 32'({rd_n, wr_n, den_n, bhe_n}), 32'hF);
    check("R1 reset ale/oe/done", 32'({ale, ad_oe, rsp_valid}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    send(1, 0, 20'hA_1234, 1, 16'h0000, 16'hBEEF, 0); // R8 no waits, read
    send(1, 1, 20'h5_0F0E, 0, 16'h1357, 16'h0000, 0); // R11 back to back
    send(0, 0, 20'h0_0040, 0, 16'h0000, 16'h00A5, 3);
    send(0, 1, 20'hF_FFFE, 1, 16'hC3C3, 16'h0000, 1);
    send(1, 0, 20'h3_8001, 1, 16'h0000, 16'h7E81, 5);
    send(1, 1, 20'h9_2468, 1, 16'hFFFF, 16'h0000, 2);
    repeat (4) @(negedge clk);
    send(0, 0, 20'h0_0001, 0, 16'h0000, 16'h5A5A, 1);
    repeat (15) @(negedge clk);
    check("R10 all transfers completed", 32'(n_done), 32'd7);
    check("R11 queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule